// File: doc/BRIEF.md
# Pad Function and Electrical Control Register Bank

This block is a small register file that sets up a group of up to 32 chip pins. Each pin owns one function-select register, and it alone picks the function the pad ring routes to that pin. The electrical settings are packed one bit per pin, or two bits per pin for drive strength, into a few shared words: pull-up enable, pull-down enable, slew control, open-drain enable and drive code. A parameter gives a fixed mask of the pins that are actually bonded out. The bank drives only those pins. The flops for the other pins are never built, and their outputs are tied low.

Software reaches the bank over a plain 32-bit read/write bus that takes byte addresses inside a 0x100-byte window. Several copies can therefore be placed at a 0x100 stride. Every control register holds its value and drives the matching pad control outputs directly. A new setting reaches the pads on the same clock edge that accepts the write.

Top module: `padmux_bank`

## Requirements
- R1: While reset is asserted (rstN low), and after it is released, every pad output is zero, busRdValid is zero and busRdata is zero. Zero means GPIO function, no pulls, default slew, push-pull and drive code 0.
- R2: The select register for pin n is at byte offset 4*n, for n below NUM_PINS. A write stores busWdata[3:0] for that pin and discards the upper bits. A read returns the stored 4-bit value with zeros above it. A select value of 0 chooses the GPIO function.
- R3: Offset 0x80 is pull-up enable and offset 0x84 is pull-down enable. In both, bit n belongs to pin n.
- R4: Offset 0x88 is slew control and offset 0x94 is open-drain enable. In both, bit n belongs to pin n.
- R5: Drive codes are two bits per pin. Pins 0..15 are at 0x8C and pins 16..31 are at 0x90. Pin n uses register bits [2*(n%16)+1 : 2*(n%16)], and that code appears on padDrive[2n+1:2n].
- R6: Offset 0x98 is read-only and returns the availability mask, with bit n set when pin n exists. Writes to 0x98 change nothing.
- R7: For a pin whose availability bit is clear: writes to its select register are ignored, and reads of that register return zero. Its bits in the packed registers read as zero. All of its pad outputs stay zero.
- R8: The following offsets are unmapped: any offset whose two low bits are non-zero, offsets 0x9C..0xFF, and select slots at or above NUM_PINS. Unmapped offsets read as zero, and writes to them change nothing.
- R9: If busRdEn is high on a clock edge, busRdValid is high and busRdata holds the value of the addressed register as it was before that edge. A write in the same cycle is not yet visible to that read. Back-to-back reads return one result per cycle.
- R10: Pin n's select value drives padMuxSel[4n+3:4n]. A write changes the pad outputs on the clock edge that accepts it, and no pad output changes in a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset within the bank window |
| busWrEn | input | 1 | Write strobe for one cycle |
| busRdEn | input | 1 | Read strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | High one cycle after a read strobe |
| padMuxSel | output | NUM_PINS*4 | Function select per pin, 4 bits each |
| padPullUp | output | NUM_PINS | Pull-up enable per pin |
| padPullDown | output | NUM_PINS | Pull-down enable per pin |
| padSlew | output | NUM_PINS | Slew control per pin |
| padOpenDrain | output | NUM_PINS | Open-drain enable per pin |
| padDrive | output | NUM_PINS*2 | Drive code per pin, 2 bits each |

## Verification
Every control flop drives a pad output directly, so a corrupted setting shows up on the pad vectors in the very cycle after the write that caused it. The bench compares all pad outputs against its own model after each write. Several faults are invisible on the pad side: a wrong address decode, a wrong drive-field placement, or a leak into an absent pin. These appear as a wrong word on busRdata exactly one cycle after the read strobe. The scoreboard checks every returned word, including reads that collide with a write in the same cycle and reads of holes in the map.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
  localparam int PIN_IDX_W = 5;

  localparam logic [7:0] OFF_PULLUP = 8'h80;
  localparam logic [7:0] OFF_PULLDN = 8'h84;
  localparam logic [7:0] OFF_SLEW   = 8'h88;
  localparam logic [7:0] OFF_DRVLO  = 8'h8C;
  localparam logic [7:0] OFF_DRVHI  = 8'h90;
  localparam logic [7:0] OFF_ODRAIN = 8'h94;
  localparam logic [7:0] OFF_AVAIL  = 8'h98;

  typedef enum logic [3:0] {
    RS_NONE, RS_MUX, RS_PULLUP, RS_PULLDN, RS_SLEW,
    RS_DRVLO, RS_DRVHI, RS_ODRAIN, RS_AVAIL
  } rdSel_e;

  typedef struct packed {
    logic                 wrMux;
    logic                 wrPullUp;
    logic                 wrPullDn;
    logic                 wrSlew;
    logic                 wrDrvLo;
    logic                 wrDrvHi;
    logic                 wrODrain;
    logic [PIN_IDX_W-1:0] pinIdx;
    rdSel_e               rdSel;
    logic                 rdStb;
  } bankStrobe_t;
endpackage

// File: rtl/padmux_ctrl.sv
module padmux_ctrl
  import padmux_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  output bankStrobe_t strobe
);
  localparam logic [5:0] PIN_LIMIT = 6'(NUM_PINS);

  logic aligned;
  logic inMuxWin;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign inMuxWin = aligned && !busAddr[7] && ({1'b0, busAddr[6:2]} < PIN_LIMIT);

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RS_NONE;
    strobe.pinIdx = busAddr[6:2];
    strobe.rdStb  = busRdEn;
    if (inMuxWin) begin
      strobe.wrMux = busWrEn;
      strobe.rdSel = RS_MUX;
    end else if (aligned) begin
      case (busAddr)
        OFF_PULLUP: begin strobe.wrPullUp = busWrEn; strobe.rdSel = RS_PULLUP; end
        OFF_PULLDN: begin strobe.wrPullDn = busWrEn; strobe.rdSel = RS_PULLDN; end
        OFF_SLEW:   begin strobe.wrSlew   = busWrEn; strobe.rdSel = RS_SLEW;   end
        OFF_DRVLO:  begin strobe.wrDrvLo  = busWrEn; strobe.rdSel = RS_DRVLO;  end
        OFF_DRVHI:  begin strobe.wrDrvHi  = busWrEn; strobe.rdSel = RS_DRVHI;  end
        OFF_ODRAIN: begin strobe.wrODrain = busWrEn; strobe.rdSel = RS_ODRAIN; end
        OFF_AVAIL:  strobe.rdSel = RS_AVAIL;
        default:    strobe.rdSel = RS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/padmux_dp.sv
module padmux_dp
  import padmux_pkg::*;
#(
  parameter int                  NUM_PINS  = 32,
  parameter int                  SEL_W     = 4,
  parameter logic [NUM_PINS-1:0] AVAIL_MAP = '1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bankStrobe_t                 strobe,
  input  logic [31:0]                 busWdata,
  output logic [31:0]                 busRdata,
  output logic                        busRdValid,
  output logic [NUM_PINS*SEL_W-1:0]   padMuxSel,
  output logic [NUM_PINS-1:0]         padPullUp,
  output logic [NUM_PINS-1:0]         padPullDown,
  output logic [NUM_PINS-1:0]         padSlew,
  output logic [NUM_PINS-1:0]         padOpenDrain,
  output logic [2*NUM_PINS-1:0]       padDrive
);
  localparam int PINS_PER_DRV = 16;

  logic [SEL_W-1:0] selArr [NUM_PINS];

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int  SLOT  = n % PINS_PER_DRV;
    localparam bit  UPPER = (n >= PINS_PER_DRV);
    if (AVAIL_MAP[n]) begin : g_live
      logic [SEL_W-1:0] selQ;
      logic             puQ, pdQ, slewQ, odQ;
      logic [1:0]       drvQ;
      logic             drvWr;
      assign drvWr = UPPER ? strobe.wrDrvHi : strobe.wrDrvLo;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          selQ  <= '0;
          puQ   <= 1'b0;
          pdQ   <= 1'b0;
          slewQ <= 1'b0;
          odQ   <= 1'b0;
          drvQ  <= 2'b00;
        end else begin
          if (strobe.wrMux && strobe.pinIdx == PIN_IDX_W'(n)) selQ <= busWdata[SEL_W-1:0];
          if (strobe.wrPullUp) puQ   <= busWdata[n];
          if (strobe.wrPullDn) pdQ   <= busWdata[n];
          if (strobe.wrSlew)   slewQ <= busWdata[n];
          if (strobe.wrODrain) odQ   <= busWdata[n];
          if (drvWr)           drvQ  <= busWdata[2*SLOT +: 2];
        end
      end
      assign selArr[n]                   = selQ;
      assign padPullUp[n]                = puQ;
      assign padPullDown[n]              = pdQ;
      assign padSlew[n]                  = slewQ;
      assign padOpenDrain[n]             = odQ;
      assign padDrive[2*n +: 2]          = drvQ;
    end else begin : g_absent
      assign selArr[n]                   = '0;
      assign padPullUp[n]                = 1'b0;
      assign padPullDown[n]              = 1'b0;
      assign padSlew[n]                  = 1'b0;
      assign padOpenDrain[n]             = 1'b0;
      assign padDrive[2*n +: 2]          = 2'b00;
    end
    assign padMuxSel[n*SEL_W +: SEL_W] = selArr[n];
  end

  logic [63:0] drvWide;
  logic [31:0] rdNext;
  logic [31:0] selWord;

  assign drvWide = 64'(padDrive);

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (strobe.pinIdx == PIN_IDX_W'(i)) selWord = 32'(selArr[i]);
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RS_MUX:    rdNext = selWord;
      RS_PULLUP: rdNext = 32'(padPullUp);
      RS_PULLDN: rdNext = 32'(padPullDown);
      RS_SLEW:   rdNext = 32'(padSlew);
      RS_ODRAIN: rdNext = 32'(padOpenDrain);
      RS_DRVLO:  rdNext = drvWide[31:0];
      RS_DRVHI:  rdNext = drvWide[63:32];
      RS_AVAIL:  rdNext = 32'(AVAIL_MAP);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata   <= '0;
      busRdValid <= 1'b0;
    end else begin
      busRdValid <= strobe.rdStb;
      if (strobe.rdStb) busRdata <= rdNext;
    end
  end
endmodule

// File: rtl/padmux_bank.sv
module padmux_bank
  import padmux_pkg::*;
#(
  parameter int                  NUM_PINS  = 32,
  parameter int                  SEL_W     = 4,
  parameter logic [NUM_PINS-1:0] AVAIL_MAP = 32'hFFFF_7FEF
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [7:0]                busAddr,
  input  logic                      busWrEn,
  input  logic                      busRdEn,
  input  logic [31:0]               busWdata,
  output logic [31:0]               busRdata,
  output logic                      busRdValid,
  output logic [NUM_PINS*SEL_W-1:0] padMuxSel,
  output logic [NUM_PINS-1:0]       padPullUp,
  output logic [NUM_PINS-1:0]       padPullDown,
  output logic [NUM_PINS-1:0]       padSlew,
  output logic [NUM_PINS-1:0]       padOpenDrain,
  output logic [2*NUM_PINS-1:0]     padDrive
);
  bankStrobe_t strobe;

  padmux_ctrl #(.NUM_PINS(NUM_PINS)) ctrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  padmux_dp #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .AVAIL_MAP(AVAIL_MAP)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .busRdValid   (busRdValid),
    .padMuxSel    (padMuxSel),
    .padPullUp    (padPullUp),
    .padPullDown  (padPullDown),
    .padSlew      (padSlew),
    .padOpenDrain (padOpenDrain),
    .padDrive     (padDrive)
  );
endmodule

// File: rtl/padmux_bank_chk.sv
module padmux_bank_chk #(
  parameter int                  NUM_PINS  = 32,
  parameter int                  SEL_W     = 4,
  parameter logic [NUM_PINS-1:0] AVAIL_MAP = '1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [7:0]                busAddr,
  input logic                      busWrEn,
  input logic                      busRdEn,
  input logic [31:0]               busWdata,
  input logic [31:0]               busRdata,
  input logic                      busRdValid,
  input logic [NUM_PINS*SEL_W-1:0] padMuxSel,
  input logic [NUM_PINS-1:0]       padPullUp,
  input logic [NUM_PINS-1:0]       padPullDown,
  input logic [NUM_PINS-1:0]       padSlew,
  input logic [NUM_PINS-1:0]       padOpenDrain,
  input logic [2*NUM_PINS-1:0]     padDrive
);
  localparam logic [31:0] AVAIL_W = 32'(AVAIL_MAP);

  logic [4:0]       lastIdx;
  logic [SEL_W-1:0] selAtLast;
  logic             liveMuxWr;
  logic             holeAddr;
  logic             absentActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastIdx <= '0;
    else       lastIdx <= busAddr[6:2];
  end

  always_comb begin
    selAtLast    = '0;
    absentActive = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (lastIdx == 5'(i)) selAtLast = padMuxSel[i*SEL_W +: SEL_W];
      if (!AVAIL_MAP[i] && (padMuxSel[i*SEL_W +: SEL_W] != '0 || padPullUp[i] ||
          padPullDown[i] || padSlew[i] || padOpenDrain[i] || padDrive[2*i +: 2] != 2'b00))
        absentActive = 1'b1;
    end
  end

  assign liveMuxWr = busWrEn && !busAddr[7] && busAddr[1:0] == 2'b00 &&
                     (32'(busAddr[6:2]) < 32'(NUM_PINS)) && AVAIL_W[busAddr[6:2]];
  assign holeAddr  = (busAddr[1:0] != 2'b00) || (busAddr >= 8'h9C) ||
                     (!busAddr[7] && (32'(busAddr[6:2]) >= 32'(NUM_PINS)));

  // R2 / R10: a write to a live select slot lands in that pin's field
  a_r2_mux_write: assert property (@(posedge clk) disable iff (!rstN)
    liveMuxWr |=> selAtLast == $past(busWdata[SEL_W-1:0]));

  // R7: absent pins never drive anything
  a_r7_absent_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !absentActive);

  // R10: no write, no pad change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(padMuxSel) && $stable(padPullUp) && $stable(padPullDown) &&
                  $stable(padSlew) && $stable(padOpenDrain) && $stable(padDrive)));

  // R9: read result valid exactly one cycle after the strobe
  a_r9_rd_valid: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid);

  // R6: availability mask read
  a_r6_avail_read: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 8'h98) |=> busRdata == AVAIL_W);

  // R8: holes in the map read zero
  a_r8_hole_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && holeAddr) |=> busRdata == 32'h0);
endmodule

bind padmux_bank padmux_bank_chk #(
  .NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .AVAIL_MAP(AVAIL_MAP)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busWdata(busWdata), .busRdata(busRdata), .busRdValid(busRdValid),
  .padMuxSel(padMuxSel), .padPullUp(padPullUp), .padPullDown(padPullDown),
  .padSlew(padSlew), .padOpenDrain(padOpenDrain), .padDrive(padDrive)
);

// File: tb/padmux_bank_tb_top.sv
`timescale 1ns/1ps
module padmux_bank_tb_top;
  localparam int          NP = 32;
  localparam int          SW = 4;
  localparam logic [31:0] AV = 32'hFFFF_7FEF;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [7:0]          busAddr = '0;
  logic                busWrEn = 1'b0;
  logic                busRdEn = 1'b0;
  logic [31:0]         busWdata = '0;
  logic [31:0]         busRdata;
  logic                busRdValid;
  logic [NP*SW-1:0]    padMuxSel;
  logic [NP-1:0]       padPullUp, padPullDown, padSlew, padOpenDrain;
  logic [2*NP-1:0]     padDrive;

  always #2 clk = ~clk;

  padmux_bank #(.NUM_PINS(NP), .SEL_W(SW), .AVAIL_MAP(AV)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWdata(busWdata), .busRdata(busRdata), .busRdValid(busRdValid),
    .padMuxSel(padMuxSel), .padPullUp(padPullUp), .padPullDown(padPullDown),
    .padSlew(padSlew), .padOpenDrain(padOpenDrain), .padDrive(padDrive)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  logic [3:0]  mSel [NP];
  logic [31:0] mPu, mPd, mSlew, mOd;
  logic [63:0] mDrv;

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(logic [7:0] a);
    logic [31:0] r;
    r = '0;
    if (a[1:0] == 2'b00) begin
      if (!a[7]) r = {28'h0, mSel[a[6:2]]};
      else case (a)
        8'h80: r = mPu;
        8'h84: r = mPd;
        8'h88: r = mSlew;
        8'h8C: r = mDrv[31:0];
        8'h90: r = mDrv[63:32];
        8'h94: r = mOd;
        8'h98: r = AV;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic modelWrite(logic [7:0] a, logic [31:0] d);
    if (a[1:0] == 2'b00) begin
      if (!a[7]) begin
        if (AV[a[6:2]]) mSel[a[6:2]] = d[3:0];
      end else case (a)
        8'h80: mPu   = d & AV;
        8'h84: mPd   = d & AV;
        8'h88: mSlew = d & AV;
        8'h94: mOd   = d & AV;
        8'h8C: for (int p = 0; p < 16; p++) if (AV[p]) mDrv[2*p +: 2] = d[2*p +: 2];
        8'h90: for (int p = 16; p < 32; p++) if (AV[p]) mDrv[2*p +: 2] = d[2*(p-16) +: 2];
        default: ;
      endcase
    end
  endtask

  task automatic checkPads(string tag);
    logic [127:0] es;
    for (int p = 0; p < NP; p++) es[p*4 +: 4] = mSel[p];
    check({tag, " padMuxSel"}, padMuxSel, es);
    check({tag, " padPullUp"}, 128'(padPullUp), 128'(mPu));
    check({tag, " padPullDown"}, 128'(padPullDown), 128'(mPd));
    check({tag, " padSlew"}, 128'(padSlew), 128'(mSlew));
    check({tag, " padOpenDrain"}, 128'(padOpenDrain), 128'(mOd));
    check({tag, " padDrive"}, 128'(padDrive), 128'(mDrv));
  endtask

  // All bus tasks start and end on a falling edge.
  task automatic doWrite(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic doRead(logic [7:0] a, string tag);
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back(modelRead(a));
    tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic doRdWr(logic [7:0] a, logic [31:0] d, string tag);
    busAddr = a; busWdata = d; busRdEn = 1'b1; busWrEn = 1'b1;
    expQ.push_back(modelRead(a));
    tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0; busWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected read result: actual %h expected none", busRdata);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, 128'(busRdata), 128'(e));
      end
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) mSel[p] = '0;
    mPu = '0; mPd = '0; mSlew = '0; mOd = '0; mDrv = '0;
    repeat (3) @(negedge clk);
    // R1: state under reset
    checkPads("R1 in reset");
    check("R1 rdValid in reset", 128'(busRdValid), 128'(0));
    rstN = 1'b1;
    @(negedge clk);
    checkPads("R1 after reset");
    check("R1 rdata after reset", 128'(busRdata), 128'(0));

    doRead(8'h98, "R6 avail read");
    doRead(8'h00, "R1 mux0 reset value");
    doRead(8'h8C, "R1 drive reset value");

    // R2 / R10: select writes, upper bits dropped
    doWrite(8'h00, 32'h0000_0005);
    doWrite(8'h7C, 32'hFFFF_FFFA);
    doWrite(8'h24, 32'h0000_0009);
    checkPads("R2 R10 select writes");
    // R7: absent pins 4 and 15
    doWrite(8'h10, 32'h0000_0007);
    doWrite(8'h3C, 32'h0000_000C);
    checkPads("R7 absent select write");
    doRead(8'h00, "R2 read pin0");
    doRead(8'h7C, "R2 read pin31 upper dropped");
    doRead(8'h10, "R7 read absent pin4");
    doRead(8'h3C, "R7 read absent pin15");

    // R3 / R4 packed bit registers
    doWrite(8'h80, 32'hFFFF_FFFF);
    doWrite(8'h84, 32'hA5A5_A5A5);
    doWrite(8'h88, 32'h0F0F_F0F0);
    doWrite(8'h94, 32'h8001_8011);
    checkPads("R3 R4 R7 packed bits");
    doRead(8'h80, "R3 pullup read");
    doRead(8'h84, "R3 pulldown read");
    doRead(8'h88, "R4 slew read");
    doRead(8'h94, "R4 open-drain read");

    // R5 drive fields
    doWrite(8'h8C, 32'hE4E4_1B1B);
    doWrite(8'h90, 32'h1234_5678);
    checkPads("R5 drive codes");
    check("R5 pin1 code", 128'(padDrive[3:2]), 128'(2'b10));
    check("R5 pin31 code", 128'(padDrive[63:62]), 128'(2'b00));
    doRead(8'h8C, "R5 drive lo read");
    doRead(8'h90, "R5 drive hi read");

    // R6 / R8: writes to read-only and holes change nothing
    doWrite(8'h98, 32'h0000_0000);
    doWrite(8'h9C, 32'hFFFF_FFFF);
    doWrite(8'hFC, 32'hFFFF_FFFF);
    doWrite(8'h81, 32'h0000_0000);
    doWrite(8'h02, 32'h0000_000F);
    checkPads("R6 R8 ignored writes");
    doRead(8'h98, "R6 avail after write");
    doRead(8'h9C, "R8 hole 0x9C");
    doRead(8'hF0, "R8 hole 0xF0");
    doRead(8'h85, "R8 misaligned read");

    // R9: read colliding with write returns the old value
    doRdWr(8'h84, 32'h0000_FFFF, "R9 read-during-write pulldown");
    doRead(8'h84, "R9 value after collision");
    doRdWr(8'h24, 32'h0000_0003, "R9 read-during-write select");
    checkPads("R9 pads after collision");

    // R2: back to GPIO
    doWrite(8'h00, 32'h0000_0000);
    checkPads("R2 select back to GPIO");
    doRead(8'h00, "R2 pin0 GPIO readback");

    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", 128'(expQ.size()), 128'(0));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule